// File: doc/BRIEF.md
# SPI Status Register Write-Protect Controller

This block is the target-side logic of a serial flash that receives the status-register write command over SPI. Chip-select, serial clock, data-in and the active-low write-protect pin are oversampled by the chip clock through synchronizer stages. Data is taken on rising serial-clock edges with the most significant bit first, so both SPI mode 0 and mode 3 work. A one-byte enable frame arms a write-enable latch. A following two-byte frame carries the write opcode and the new register value. That value is committed only when chip-select rises at the end of a frame of exactly sixteen bits.

The register holds three block-protect bits and one lock bit. The lock bit and the write-protect pin, sampled when chip-select rises, decide whether a write goes through. While the pin is low and the lock bit is set, the write is dropped. In every other case one write may change all four protect bits together, including setting the lock bit. The register image, with the enable latch in it, is an output for the read-status path. The data output is never driven for these commands.

Top module: `spi_srwp_ctrl`

## Requirements
- R1: Synchronous reset forces the status image to 0x00: all protect bits and the enable latch are cleared.
- R2: Bits are taken on rising serial-clock edges, MSB first, while chip-select is low. Frames sent in SPI mode 0 (clock idle low) and in mode 3 (clock idle high) give the same results.
- R3: An 8-bit frame carrying opcode 0x06 or 0x50 sets the enable latch when chip-select rises. The latch reads back as status bit 1.
- R4: A 16-bit frame with opcode 0x01 and data byte D, sent while the enable latch is set, copies D bits 2, 3 and 4 (block-protect 0..2) and D bit 7 (lock) into the same status positions when chip-select rises. Status bits 0, 5 and 6 always read 0, whatever D holds.
- R5: A write frame with opcode 0x01 that arrives while the enable latch is clear leaves the protect bits unchanged.
- R6: Any frame whose first eight bits are 0x01 clears the enable latch when chip-select rises. If the bit count is not exactly 16, the frame is aborted and the protect bits are not written.
- R7: When the write-protect pin is low at the chip-select rise and the lock bit is 1, the write is ignored and all four protect bits keep their values.
- R8: When the write-protect pin is low and the lock bit is 0, one write can set the lock bit and change all three block-protect bits at the same time.
- R9: When the write-protect pin is high, all four protect bits can be written, and the lock bit can be cleared.
- R10: The write-protect pin counts only at the chip-select rise. Its level while bits are being shifted has no effect.
- R11: The data-output enable stays low (high impedance) at all times, and the data output is held at 0.
- R12: The protect bits change only when chip-select rises at the end of a frame. A frame with any other opcode leaves the protect bits and the enable latch unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Chip clock used to oversample the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | SPI chip-select, active low |
| sck | input | 1 | SPI serial clock |
| mosi | input | 1 | SPI data into the target |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| miso | output | 1 | SPI data out of the target, held at 0 |
| miso_oe | output | 1 | Output enable for miso, 0 means high impedance |
| status | output | 8 | Status image: bit 7 lock, bits 4..2 block-protect, bit 1 enable latch |

## Verification
Write frames are sent in mode 0 and in mode 3, with data bytes that set the read-only bits. This separates correct bit placement from a plain byte copy. The enable latch is tested with both enable opcodes, with no enable at all, and with 15-bit and 17-bit write frames. These cases show whether the latch is consumed and whether a frame is committed only at exactly sixteen bits. The write-protect pin is set low and high with the lock bit both set and clear, and it is also changed between the shifting phase and the chip-select rise. This shows that the pin is sampled only at the end of the frame.

// File: rtl/spi_srwp_pkg.sv
package spi_srwp_pkg;

    localparam int OP_BITS    = 8;
    localparam int FRAME_BITS = 16;
    localparam int SR_W       = 8;

    localparam logic [7:0] OPC_EN_A  = 8'h06;
    localparam logic [7:0] OPC_EN_B  = 8'h50;
    localparam logic [7:0] OPC_WRITE = 8'h01;

    localparam int POS_BP0  = 2;
    localparam int POS_BP1  = 3;
    localparam int POS_BP2  = 4;
    localparam int POS_LOCK = 7;
    localparam int POS_WEL  = 1;

    typedef struct packed {
        logic       lock;
        logic [2:0] bp;
    } prot_t;

    typedef enum logic [1:0] {
        FK_OTHER  = 2'd0,
        FK_ENABLE = 2'd1,
        FK_WRITE  = 2'd2,
        FK_ABORT  = 2'd3
    } frame_kind_t;

    typedef struct packed {
        frame_kind_t kind;
        logic [7:0]  data;
    } frame_t;

    function automatic logic is_enable_op(input logic [7:0] op);
        return (op == OPC_EN_A) || (op == OPC_EN_B);
    endfunction

    function automatic prot_t prot_from_byte(input logic [7:0] d);
        prot_t p;
        p.lock = d[POS_LOCK];
        p.bp   = {d[POS_BP2], d[POS_BP1], d[POS_BP0]};
        return p;
    endfunction

    function automatic logic [SR_W-1:0] status_image(input prot_t p, input logic wel);
        logic [SR_W-1:0] s;
        s           = '0;
        s[POS_LOCK] = p.lock;
        s[POS_BP2]  = p.bp[2];
        s[POS_BP1]  = p.bp[1];
        s[POS_BP0]  = p.bp[0];
        s[POS_WEL]  = wel;
        return s;
    endfunction

    function automatic logic write_permitted(input logic wp_n_level, input prot_t cur);
        return wp_n_level || !cur.lock;
    endfunction

endpackage

// File: rtl/spi_srwp_sync.sv
module spi_srwp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    input  logic wp_n,
    output logic cs_n_s,
    output logic mosi_s,
    output logic wp_n_s,
    output logic sck_rise,
    output logic cs_rise
);
    localparam int         BUNDLE_W = 4;
    localparam logic [3:0] RST_VEC  = 4'b1001;

    logic [STAGES-1:0][BUNDLE_W-1:0] stg;
    logic [BUNDLE_W-1:0]             raw;
    logic [BUNDLE_W-1:0]             last;
    logic                            sck_s;
    logic                            sck_d;
    logic                            cs_d;

    assign raw = {wp_n, mosi, sck, cs_n};

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) stg <= RST_VEC;
                else     stg <= raw;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stg <= {STAGES{RST_VEC}};
                else     stg <= {stg[STAGES-2:0], raw};
            end
        end
    endgenerate

    assign last   = stg[STAGES-1];
    assign cs_n_s = last[0];
    assign sck_s  = last[1];
    assign mosi_s = last[2];
    assign wp_n_s = last[3];

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            sck_d <= sck_s;
            cs_d  <= cs_n_s;
        end
    end

    assign sck_rise = sck_s & ~sck_d & ~cs_n_s;
    assign cs_rise  = cs_n_s & ~cs_d;

endmodule

// File: rtl/spi_srwp_rx.sv
module spi_srwp_rx
    import spi_srwp_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   cs_n_s,
    input  logic   sck_rise,
    input  logic   mosi_s,
    output frame_t frame
);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_OP   = CNT_W'(OP_BITS);
    localparam logic [CNT_W-1:0] CNT_OPL  = CNT_W'(OP_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

    logic [FRAME_BITS-1:0] shreg;
    logic [CNT_W-1:0]      cnt;
    logic [OP_BITS-1:0]    opcode;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg  <= '0;
            cnt    <= '0;
            opcode <= '0;
        end else if (cs_n_s) begin
            cnt <= '0;
        end else if (sck_rise) begin
            shreg <= {shreg[FRAME_BITS-2:0], mosi_s};
            if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
            if (cnt == CNT_OPL) opcode <= {shreg[OP_BITS-2:0], mosi_s};
        end
    end

    always_comb begin
        frame.kind = FK_OTHER;
        frame.data = shreg[7:0];
        if (cnt >= CNT_OP) begin
            if (opcode == OPC_WRITE)
                frame.kind = (cnt == CNT_FULL) ? FK_WRITE : FK_ABORT;
            else if (is_enable_op(opcode) && cnt == CNT_OP)
                frame.kind = FK_ENABLE;
        end
    end

endmodule

// File: rtl/spi_srwp_reg.sv
module spi_srwp_reg
    import spi_srwp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   frame_end,
    input  frame_t frame,
    input  logic   wp_n_s,
    output prot_t  prot,
    output logic   wel
);
    always_ff @(posedge clk) begin
        if (rst) begin
            prot <= '0;
            wel  <= 1'b0;
        end else if (frame_end) begin
            unique case (frame.kind)
                FK_ENABLE: wel <= 1'b1;
                FK_WRITE: begin
                    wel <= 1'b0;
                    if (wel && write_permitted(wp_n_s, prot))
                        prot <= prot_from_byte(frame.data);
                end
                FK_ABORT: wel <= 1'b0;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/spi_srwp_ctrl.sv
module spi_srwp_ctrl
    import spi_srwp_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cs_n,
    input  logic            sck,
    input  logic            mosi,
    input  logic            wp_n,
    output logic            miso,
    output logic            miso_oe,
    output logic [SR_W-1:0] status
);
    logic   cs_n_s;
    logic   mosi_s;
    logic   wp_n_s;
    logic   sck_rise;
    logic   frame_end;
    frame_t frm;
    prot_t  prot;
    logic   wel;

    spi_srwp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .sck      (sck),
        .mosi     (mosi),
        .wp_n     (wp_n),
        .cs_n_s   (cs_n_s),
        .mosi_s   (mosi_s),
        .wp_n_s   (wp_n_s),
        .sck_rise (sck_rise),
        .cs_rise  (frame_end)
    );

    spi_srwp_rx #(.CNT_W(CNT_W)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .cs_n_s   (cs_n_s),
        .sck_rise (sck_rise),
        .mosi_s   (mosi_s),
        .frame    (frm)
    );

    spi_srwp_reg u_reg (
        .clk       (clk),
        .rst       (rst),
        .frame_end (frame_end),
        .frame     (frm),
        .wp_n_s    (wp_n_s),
        .prot      (prot),
        .wel       (wel)
    );

    assign status  = status_image(prot, wel);
    assign miso    = 1'b0;
    assign miso_oe = 1'b0;

endmodule

// File: rtl/spi_srwp_chk.sv
module spi_srwp_chk
    import spi_srwp_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            frame_end,
    input frame_kind_t     kind,
    input logic            wp_n_s,
    input logic [SR_W-1:0] status
);
    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> status == 8'h00); // R1

    AST_ENABLE_ARMS: assert property (@(posedge clk) disable iff (rst)
        frame_end && kind == FK_ENABLE |=> status[POS_WEL]); // R3

    AST_NO_ENABLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        frame_end && !status[POS_WEL] |=> $stable(status[7:2])); // R5

    AST_WRITE_CONSUMES: assert property (@(posedge clk) disable iff (rst)
        frame_end && (kind == FK_WRITE || kind == FK_ABORT) |=> !status[POS_WEL]); // R6

    AST_ABORT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        frame_end && kind == FK_ABORT |=> $stable(status[7:2])); // R6

    AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (rst)
        frame_end && !wp_n_s && status[POS_LOCK] |=> $stable(status[7:2])); // R7

    AST_ONLY_AT_END: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(status[7:2])); // R12

endmodule

bind spi_srwp_ctrl spi_srwp_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .frame_end (frame_end),
    .kind      (frm.kind),
    .wp_n_s    (wp_n_s),
    .status    (status)
);

// File: tb/tb_spi_srwp_ctrl.sv
module tb_spi_srwp_ctrl;

    localparam int HALF = 4;
    localparam int WATCHDOG_CYCLES = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       sck = 1'b0;
    logic       mosi = 1'b0;
    logic       wp_n = 1'b1;
    logic       miso;
    logic       miso_oe;
    logic [7:0] status;

    int n_checks = 0;
    int n_fail   = 0;
    bit oe_seen  = 1'b0;
    bit done     = 1'b0;

    spi_srwp_ctrl dut (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (cs_n),
        .sck     (sck),
        .mosi    (mosi),
        .wp_n    (wp_n),
        .miso    (miso),
        .miso_oe (miso_oe),
        .status  (status)
    );

    always #10 clk = ~clk;

    always @(negedge clk) if (miso_oe !== 1'b0 || miso !== 1'b0) oe_seen = 1'b1;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: status got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic xfer(input logic [23:0] val, input int nbits, input bit mode3, input logic wp_end);
        sck = mode3;
        tick(HALF);
        cs_n = 1'b0;
        tick(HALF);
        for (int i = nbits - 1; i >= 0; i--) begin
            if (mode3) sck = 1'b0;
            mosi = val[i];
            tick(HALF);
            sck = 1'b1;
            tick(HALF);
            if (!mode3) sck = 1'b0;
        end
        tick(HALF);
        wp_n = wp_end;
        tick(HALF);
        cs_n = 1'b1;
        tick(10);
    endtask

    task automatic send_enable(input logic [7:0] op, input bit mode3);
        xfer({16'h0, op}, 8, mode3, wp_n);
    endtask

    task automatic send_write(input logic [7:0] d, input bit mode3, input logic wp_end);
        xfer({8'h0, 8'h01, d}, 16, mode3, wp_end);
    endtask

    task automatic t_reset;
        check("R1 reset state", status, 8'h00);
        check("R11 output enable after reset", {7'b0, miso_oe}, 8'h00);
    endtask

    task automatic t_basic_write;
        wp_n = 1'b1;
        send_enable(8'h06, 1'b0);
        check("R3 enable 0x06 sets latch", status, 8'h02);
        send_write(8'hFF, 1'b0, 1'b1);
        check("R4 write 0xFF maps protect bits, ro bits zero", status, 8'h9C);
    endtask

    task automatic t_mode3;
        send_enable(8'h50, 1'b1);
        check("R3 R2 enable 0x50 in mode 3", status, 8'h9E);
        send_write(8'h14, 1'b1, 1'b1);
        check("R9 R2 wp high clears lock in mode 3", status, 8'h14);
    endtask

    task automatic t_no_enable;
        send_write(8'h08, 1'b0, 1'b1);
        check("R5 write without enable discarded", status, 8'h14);
    endtask

    task automatic t_abort;
        send_enable(8'h06, 1'b0);
        xfer({9'h0, 8'h01, 7'h7F}, 15, 1'b0, 1'b1);
        check("R6 15-bit write aborted and enable consumed", status, 8'h14);
        send_enable(8'h06, 1'b0);
        xfer({7'h0, 8'h01, 8'h88, 1'b1}, 17, 1'b0, 1'b1);
        check("R6 17-bit write aborted and enable consumed", status, 8'h14);
    endtask

    task automatic t_other_op;
        send_enable(8'h06, 1'b0);
        xfer({16'h0, 8'h9F}, 8, 1'b0, 1'b1);
        xfer({8'h0, 8'h05, 8'hFF}, 16, 1'b0, 1'b1);
        check("R12 unknown opcodes keep protect bits and enable", status, 8'h16);
        wp_n = 1'b0;
        send_write(8'h88, 1'b0, 1'b0);
        check("R8 wp low lock clear: set lock and change bp together", status, 8'h88);
    endtask

    task automatic t_locked;
        wp_n = 1'b0;
        send_enable(8'h06, 1'b0);
        check("R3 enable accepted while locked", status, 8'h8A);
        send_write(8'h00, 1'b0, 1'b0);
        check("R7 wp low and lock set: write ignored", status, 8'h88);
    endtask

    task automatic t_wp_sample;
        wp_n = 1'b0;
        send_enable(8'h06, 1'b0);
        send_write(8'h00, 1'b0, 1'b1);
        check("R10 wp low while shifting, high at end: write applied", status, 8'h00);
        wp_n = 1'b1;
        send_enable(8'h06, 1'b0);
        send_write(8'h80, 1'b0, 1'b1);
        check("R9 wp high sets lock", status, 8'h80);
        send_enable(8'h06, 1'b0);
        send_write(8'h1C, 1'b0, 1'b0);
        check("R10 wp high while shifting, low at end: write ignored", status, 8'h80);
        wp_n = 1'b1;
        send_enable(8'h06, 1'b1);
        send_write(8'h0C, 1'b1, 1'b1);
        check("R9 wp high clears lock and rewrites bp", status, 8'h0C);
    endtask

    task automatic t_mid_reset;
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
        tick(2);
        check("R1 reset clears protect bits", status, 8'h00);
    endtask

    initial begin
        rst = 1'b1;
        tick(5);
        rst = 1'b0;
        tick(5);
        t_reset();
        t_basic_write();
        t_mode3();
        t_no_enable();
        t_abort();
        t_other_op();
        t_locked();
        t_wp_sample();
        t_mid_reset();
        n_checks++;
        if (oe_seen) begin
            n_fail++;
            $display("FAIL R11: data output driven, got oe=1 or miso=1 expected 0");
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < WATCHDOG_CYCLES; c++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule